// File: doc/BRIEF.md
# Transmit Packet Buffer with Register Front End

A host loads outgoing packet words through a small 32-bit register window. It then hands each packet to the stream side by writing its byte count. The block keeps the words in a 512-entry store. Each committed group of words goes out as one frame on a valid/ready stream. The first word of a frame is marked with a start flag and the last word with an end flag. A word moves only in a cycle where `m_valid` and `m_ready` are both high. While `m_ready` is low, the offered word, its flags and `m_valid` stay unchanged. The one exception is a cycle in which a reset or a reset request arrives.

A host reads the free space as a live count, which the host uses to pace its writes. This count holds back two entries of the store. One is kept for the packet length and one is a fill margin. The count therefore reads 510 when the buffer is empty.

The host can clear the buffer with a keyed write, and that clear waits until the current frame has ended. A sink that stalls in mid-frame would hold off this clear forever. For that case a separate stream reset pin clears the block at once.

Top module: `txpkt_fifo`

## Requirements
- R1: After `rst_n` is released, the free count reads 510, `m_valid` is low, and both sticky flags are low.
- R2: A read at address 0x0C returns the free count in the low bits and zero above them. The free count is 510 minus the number of stored words. It drops by one for each accepted data write and rises by one for each word sent. Every other address reads as zero.
- R3: A write to address 0x10 is stored when the free count is non-zero. When the free count is zero, the write is discarded and `overrun_flag` is set. The flag stays set until a reset.
- R4: A write of a byte count B to address 0x14 commits the oldest ceil(B/4) uncommitted words as one frame. The frame's first word carries `m_sof` and its last word carries `m_eof`.
- R5: A commit is rejected if it asks for fewer than 4 words, for more words than are uncommitted, or arrives while 16 frames are already waiting. A rejected commit sets the sticky `len_err_flag` and changes no stored state.
- R6: A word leaves only when `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_sof` and `m_eof` hold until the word is taken. The exception is a cycle that applies a reset or a reset request.
- R7: A write of exactly 0x000000A5 to address 0x08 requests a soft clear. Any other value written there has no effect.
- R8: A requested soft clear waits while a frame is partly sent. Once no frame is in progress, it empties the buffer and clears both flags on the next edge. No new frame starts while the request is pending.
- R9: `stream_rst` high at a clock edge clears the buffer, the frame position, the pending request and both flags, even in mid-frame.
- R10: Frames leave in commit order, and their words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_rst | input | 1 | Synchronous forced clear, not deferred |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| overrun_flag | output | 1 | Sticky: a data write was dropped |
| len_err_flag | output | 1 | Sticky: a commit was rejected |
| m_valid | output | 1 | Stream word offered |
| m_ready | input | 1 | Stream sink accepts |
| m_data | output | 32 | Stream word |
| m_sof | output | 1 | First word of frame |
| m_eof | output | 1 | Last word of frame |

## Verification
A wrong stored-word count shows up in the free count on the next read, which is the cycle after the bad edge. It also shows up as an overrun that comes too early or too late. A wrong frame position shows up at once as a misplaced `m_sof`/`m_eof` on the next offered word. A broken commit length appears within one frame, because the end flag falls on the wrong word. A soft clear applied too early cuts a frame short. One applied too late, or never, shows up as `m_valid` staying high, or the free count staying low, after the frame ends.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam logic [7:0] ADDR_KEY  = 8'h08;
  localparam logic [7:0] ADDR_FREE = 8'h0C;
  localparam logic [7:0] ADDR_DATA = 8'h10;
  localparam logic [7:0] ADDR_LEN  = 8'h14;
  localparam logic [31:0] CLEAR_KEY = 32'h0000_00A5;
  localparam int MIN_WORDS = 4;
endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] used
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else if (clr) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      used <= used + CW'(push) - CW'(pop);
    end
  end

  assign head_data = mem[rp];

  // R2
  used_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CW'(DEPTH - 2));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> used != '0);
endmodule

// File: rtl/txf_lenq.sv
module txf_lenq #(
  parameter int LW    = 10,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic [LW-1:0] head_len,
  output logic          nonempty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [LW-1:0] q [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) q[wp] <= push_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt <= cnt + NW'(push) - NW'(pop);
    end
  end

  assign head_len = q[rp];
  assign nonempty = cnt != '0;
  assign full     = cnt == NW'(DEPTH);

  // R5
  lenq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/txf_framer.sv
module txf_framer #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          has_frame,
  input  logic [LW-1:0] head_len,
  input  logic          hold,
  input  logic          m_ready,
  output logic          m_valid,
  output logic          m_sof,
  output logic          m_eof,
  output logic          fire,
  output logic          mid
);
  logic [LW-1:0] idx;

  assign mid     = idx != '0;
  assign m_valid = has_frame && (mid || !hold);
  assign m_sof   = m_valid && !mid;
  assign m_eof   = m_valid && (idx == head_len - 1'b1);
  assign fire    = m_valid && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clr)     idx <= '0;
    else if (fire)    idx <= m_eof ? '0 : idx + 1'b1;
  end

  // R4
  frame_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !m_eof && !clr |=> m_valid && !m_sof);
endmodule

// File: rtl/txpkt_fifo.sv
module txpkt_fifo #(
  parameter int DEPTH    = 512,
  parameter int LQ_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stream_rst,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        overrun_flag,
  output logic        len_err_flag,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [31:0] m_data,
  output logic        m_sof,
  output logic        m_eof
);
  import txf_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] used, free_cnt, uncom;
  logic          pend, clr, mid, fire, pop_len;
  logic          has_frame, lq_full;
  logic [CW-1:0] head_len;
  logic          key_hit, data_wr, wr_ok, len_wr, len_bad, commit;
  logic [32:0]   bytes_p3;
  logic [30:0]   req_words;

  assign data_wr  = reg_wr && reg_addr == ADDR_DATA;
  assign len_wr   = reg_wr && reg_addr == ADDR_LEN;
  assign key_hit  = reg_wr && reg_addr == ADDR_KEY && reg_wdata == CLEAR_KEY;
  assign free_cnt = CW'(DEPTH - 2) - used;
  assign wr_ok    = data_wr && free_cnt != '0 && !clr;

  assign bytes_p3  = {1'b0, reg_wdata} + 33'd3;
  assign req_words = bytes_p3[32:2];
  assign len_bad   = req_words < 31'(MIN_WORDS) || req_words > 31'(uncom) || lq_full;
  assign commit    = len_wr && !len_bad && !clr;

  assign clr = stream_rst || (pend && !mid);

  txf_store #(.DW(32), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(wr_ok), .push_data(reg_wdata),
    .pop(fire), .head_data(m_data), .used(used)
  );

  txf_lenq #(.LW(CW), .DEPTH(LQ_DEPTH)) u_lenq (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(commit), .push_len(req_words[CW-1:0]),
    .pop(pop_len), .head_len(head_len),
    .nonempty(has_frame), .full(lq_full)
  );

  txf_framer #(.LW(CW)) u_framer (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .has_frame(has_frame), .head_len(head_len), .hold(pend),
    .m_ready(m_ready), .m_valid(m_valid), .m_sof(m_sof), .m_eof(m_eof),
    .fire(fire), .mid(mid)
  );

  assign pop_len = fire && m_eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uncom        <= '0;
      pend         <= 1'b0;
      overrun_flag <= 1'b0;
      len_err_flag <= 1'b0;
    end else if (clr) begin
      uncom        <= '0;
      pend         <= 1'b0;
      overrun_flag <= 1'b0;
      len_err_flag <= 1'b0;
    end else begin
      uncom <= uncom + CW'(wr_ok) - (commit ? req_words[CW-1:0] : '0);
      if (key_hit)                         pend         <= 1'b1;
      if (data_wr && free_cnt == '0)       overrun_flag <= 1'b1;
      if (len_wr && len_bad)               len_err_flag <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_FREE) reg_rdata = 32'(free_cnt);
  end

  // R3
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && free_cnt == '0 && !clr |=> overrun_flag && $stable(used));
  // R5
  len_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr && len_bad && !clr && !fire |=> len_err_flag && $stable(uncom) && $stable(used));
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && !stream_rst && !key_hit
    |=> m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eof));
  // R8
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !mid |-> !m_valid);
  // R8
  pend_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && mid && !stream_rst |=> pend);
  // R9
  stream_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stream_rst |=> used == '0 && !m_valid && !pend);
endmodule

// File: tb/txpkt_fifo_bench.sv
module txpkt_fifo_bench;
  localparam int DEPTH = 512;
  localparam int LQ    = 16;
  localparam int CAP   = DEPTH - 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stream_rst = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        overrun_flag, len_err_flag;
  logic        m_valid, m_sof, m_eof;
  logic        m_ready = 1'b0;
  logic [31:0] m_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int q[$];
  int fl[$];
  int uncom = 0;
  int wi = 0;
  bit pend = 0, ovr = 0, lerr = 0;
  int wcount = 0;

  always #2 clk = ~clk;

  txpkt_fifo #(.DEPTH(DEPTH), .LQ_DEPTH(LQ)) u_txpkt_fifo (
    .clk(clk), .rst_n(rst_n), .stream_rst(stream_rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .overrun_flag(overrun_flag), .len_err_flag(len_err_flag),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sof(m_sof), .m_eof(m_eof)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_valid();
    return fl.size() > 0 && (wi != 0 || !pend);
  endfunction

  function automatic longint words_of(input logic [31:0] b);
    return (longint'(b) + 3) >> 2;
  endfunction

  task automatic check_outputs();
    bit ev = exp_valid();
    chk("R6 valid", 32'(m_valid), 32'(ev));
    if (ev) begin
      chk("R10 data", m_data, q[0]);
      chk("R4 sof", 32'(m_sof), 32'(wi == 0));
      chk("R4 eof", 32'(m_eof), 32'(wi == fl[0] - 1));
    end
    chk("R3 overrun flag", 32'(overrun_flag), 32'(ovr));
    chk("R5 length error flag", 32'(len_err_flag), 32'(lerr));
    if (reg_addr == 8'h0C) chk("R2 free count", reg_rdata, 32'(CAP - q.size()));
    else                   chk("R2 other address", reg_rdata, 32'h0);
  endtask

  task automatic clear_model();
    q.delete(); fl.delete();
    uncom = 0; wi = 0; pend = 0; ovr = 0; lerr = 0;
  endtask

  task automatic update(input bit w, input logic [7:0] a, input logic [31:0] d,
                        input bit rdy, input bit srst);
    bit ev = exp_valid();
    int qs = q.size();
    int fs = fl.size();
    longint wd;
    if (srst || (pend && wi == 0)) begin
      clear_model();
      return;
    end
    if (w && a == 8'h10) begin
      if (qs < CAP) begin q.push_back(d); uncom++; end
      else ovr = 1;
    end
    if (w && a == 8'h08 && d == 32'hA5) pend = 1;
    if (w && a == 8'h14) begin
      wd = words_of(d);
      if (wd < 4 || wd > uncom || fs >= LQ) lerr = 1;
      else begin fl.push_back(int'(wd)); uncom -= int'(wd); end
    end
    if (ev && rdy) begin
      void'(q.pop_front());
      wi++;
      if (wi == fl[0]) begin void'(fl.pop_front()); wi = 0; end
    end
  endtask

  task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d,
                     input bit rdy, input bit srst);
    reg_wr = w; reg_addr = a; reg_wdata = d; m_ready = rdy; stream_rst = srst;
    #1;
    check_outputs();
    @(posedge clk);
    update(w, a, d, rdy, srst);
    @(negedge clk);
  endtask

  task automatic put_words(input int n);
    for (int i = 0; i < n; i++) begin
      wcount++;
      cyc(1, 8'h10, 32'hD000_0000 + 32'(wcount), 0, 0);
    end
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) cyc(0, 8'h0C, 32'h0, rdy, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: state after reset
    reg_addr = 8'h0C; #1;
    chk("R1 free after reset", reg_rdata, 32'd510);
    chk("R1 valid after reset", 32'(m_valid), 32'h0);
    chk("R1 flags after reset", 32'({overrun_flag, len_err_flag}), 32'h0);
    @(negedge clk);

    // R4/R5: commit rules
    put_words(6);
    cyc(1, 8'h14, 32'd12, 0, 0);        // 3 words: R5 reject
    chk("R5 too short", 32'(len_err_flag), 32'h1);
    cyc(1, 8'h14, 32'd13, 0, 0);        // 4 words: R4 accept
    cyc(1, 8'h14, 32'd40, 0, 0);        // 10 > 2 uncommitted: R5 reject
    idle(3, 0);
    idle(8, 1);
    chk("R2 after frame sent", reg_rdata, 32'd508);

    // R7: wrong key values have no effect
    cyc(1, 8'h08, 32'h0000_01A5, 0, 0);
    cyc(1, 8'h08, 32'h0000_00A4, 0, 0);
    idle(2, 0);
    chk("R7 wrong key kept contents", reg_rdata, 32'd508);

    // R3: fill to overrun
    put_words(CAP);
    idle(1, 0);
    chk("R3 free zero", reg_rdata, 32'd0);
    chk("R3 overrun set", 32'(overrun_flag), 32'h1);

    // R9: stream reset clears at once
    cyc(0, 8'h0C, 0, 0, 1);
    idle(1, 0);
    chk("R9 cleared", reg_rdata, 32'd510);

    // R8: key during stalled frame waits for frame end
    put_words(5);
    cyc(1, 8'h14, 32'd20, 0, 0);
    idle(1, 1);
    cyc(1, 8'h08, 32'hA5, 0, 0);
    idle(6, 0);
    chk("R8 still valid mid-frame", 32'(m_valid), 32'h1);
    idle(6, 1);
    chk("R8 applied after frame", reg_rdata, 32'd510);

    // R9: stalled frame, key pending, forced clear
    put_words(6);
    cyc(1, 8'h14, 32'd24, 0, 0);
    idle(2, 1);
    cyc(1, 8'h08, 32'hA5, 0, 0);
    idle(4, 0);
    cyc(0, 8'h0C, 0, 0, 1);
    idle(2, 1);
    chk("R9 forced clear mid-frame", 32'(m_valid), 32'h0);

    // R10: random traffic
    for (int n = 0; n < 5000; n++) begin
      int r = $urandom % 100;
      bit rdy = ($urandom % 3) != 0;
      if ($urandom % 700 == 0) cyc(0, 8'h0C, 0, rdy, 1);
      else if (r < 45 && q.size() < 500) begin
        wcount++;
        cyc(1, 8'h10, $urandom, rdy, 0);
      end else if (r < 62 && uncom >= 4) begin
        int lim = (uncom < 24) ? uncom : 24;
        int w = 4 + int'($urandom % (lim - 3));
        cyc(1, 8'h14, 32'(w * 4 - int'($urandom % 4)), rdy, 0);
      end else if (r < 66) cyc(1, 8'h14, $urandom % 64, rdy, 0);
      else if (r < 67) cyc(1, 8'h08, 32'hA5, rdy, 0);
      else if (r < 69) cyc(1, 8'h08, $urandom | 32'h100, rdy, 0);
      else cyc(0, 8'h0C, 0, rdy, 0);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule